// File: doc/BRIEF.md
# Dual Timer Interrupt Status Controller

This block is the host-visible timer and interrupt core of a sound card's FM-compatible register set. A byte-wide write port reaches seven registers: a command register, a data port, a plain status latch, a timer control register, two 8-bit timer presets, and the timer data register, which is written through the data port. A separate read port returns any register with no side effect. The timer status register is kept by the block and can be seen at the status address. An interrupt status byte collects the pending causes and drives one level interrupt line.

Two up-counting timers reload from their presets. The fast one advances once per base tick (nominally 80 us). The slow one advances once every `SLOW_RATIO` base ticks (nominally 320 us). A timer runs while its start bit in the timer data register is set, and it expires when it overflows past 0xFF. Each expiry can set a maskable status pair and, when enabled, a non-maskable status bit plus a pending bit in the interrupt byte. The base tick comes from a parameterised clock divider, so a test can use short periods.

The host port has no back-pressure. A write is taken on every clock edge where `wr_en` is high, and reads are combinational from `rd_addr`. Register addresses (3 bits): 0 command on write and status view on read; 1 data port on write and data latch on read; 2 plain status latch on write and command on read; 3 timer control; 4 interrupt byte (read only); 5 preset of timer 1; 6 preset of timer 2; 7 timer data (read only, written through the data port).

Top module: `dual_timer_irq`

## Requirements
- R1: A read of address 0 returns the timer status register when timer-control bit 0 is 1. Otherwise it returns the plain status latch last written at address 2.
- R2: When the command register holds 0x04 and timer-control bit 0 is 0, a data-port write with bit 7 set clears timer status bits 7, 6 and 5. With bit 7 clear, the byte goes into the timer data register (read at address 7). In both cases the data latch is unchanged.
- R3: Any other data-port write goes into the data latch (read at address 1). If timer-control bit 1 is 1, that write also sets timer status bit 0 and loads the interrupt byte with 0x10.
- R4: A timer-control write with bit 5 clear clears status bits 4 and 3, and with bit 1 clear it clears status bit 0. If status bits 0, 3 and 4 are then all zero, interrupt bit 4 is cleared.
- R5: A timer-control write with bit 2 clear clears status bit 2 and interrupt bit 2. A write with bit 3 clear clears status bit 1 and interrupt bit 3.
- R6: Timer 1 runs while timer-data bit 0 is 1 and advances on each base tick; a base tick occurs once every `DIV_CYCLES` clocks. On a tick at 0xFF it expires and reloads its preset. On expiry it sets status bits 7 and 6 unless timer-data bit 6 is 1, and if timer-control bit 2 is 1 it sets status bit 2 and interrupt bit 2.
- R7: Timer 2 runs while timer-data bit 1 is 1 and advances on every `SLOW_RATIO`-th base tick. On expiry it sets status bits 7 and 5 unless timer-data bit 5 is 1, and if timer-control bit 3 is 1 it sets status bit 1 and interrupt bit 3.
- R8: `irq` is high exactly when the interrupt byte is nonzero, and it drops in the same cycle the byte becomes zero.
- R9: A stopped timer holds its preset and never expires. When an expiry and a host write fall in the same cycle, the write's effect is applied after the expiry's.
- R10: After reset every register, both timers and the divider are zero and `irq` is low. Writes to addresses 4 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read byte, combinational from rd_addr |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check four things. The acknowledge write empties the maskable status bits. The latched data write reloads the interrupt byte with 0x10. Each timer expiry raises its maskable and non-maskable bits unless a same-cycle write overrides them. A control write with every enable cleared drops the interrupt line. The bench runs a cycle-level reference model and compares every register and the line each cycle. Only the bench's scenarios can show that expiry happens at the right tick, that the slow divider ratio is correct, that the status view switches, and that stopped timers stay silent.

// File: rtl/dti_pkg.sv
package dti_pkg;
  typedef enum logic [2:0] {
    A_CMDSTAT = 3'd0,
    A_DATA    = 3'd1,
    A_AUX     = 3'd2,
    A_TCTRL   = 3'd3,
    A_ISR     = 3'd4,
    A_PRE1    = 3'd5,
    A_PRE2    = 3'd6,
    A_TDATA   = 3'd7
  } reg_addr_e;

  localparam logic [7:0] ACK_CMD   = 8'h04;
  localparam logic [7:0] LOAD_ISR  = 8'h10;
  localparam int         NUM_TMR   = 2;
  localparam int         CNT_W     = 8;

  // timer control bits
  localparam int TC_VIEW  = 0;
  localparam int TC_DIRQ  = 1;
  localparam int TC_T1EN  = 2;
  localparam int TC_T2EN  = 3;
  localparam int TC_SBEN  = 5;
endpackage

// File: rtl/dti_tick_gen.sv
module dti_tick_gen #(
  parameter int DIV_CYCLES = 4000,
  parameter int SLOW_RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_fast,
  output logic tick_slow
);
  localparam int DW = (DIV_CYCLES > 1) ? $clog2(DIV_CYCLES) : 1;
  localparam int RW = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV_CYCLES - 1);
  localparam logic [RW-1:0] RAT_LAST = RW'(SLOW_RATIO - 1);

  logic [DW-1:0] div_q;
  logic [RW-1:0] rat_q;

  assign tick_fast = (div_q == DIV_LAST);
  assign tick_slow = tick_fast && (rat_q == RAT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      rat_q <= '0;
    end else begin
      div_q <= tick_fast ? '0 : div_q + 1'b1;
      if (tick_fast)
        rat_q <= (rat_q == RAT_LAST) ? '0 : rat_q + 1'b1;
    end
  end
endmodule

// File: rtl/dti_counter.sv
module dti_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] preset,
  output logic         expire
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run)
      cnt_q <= preset;
    else if (tick)
      cnt_q <= (cnt_q == TOP) ? preset : cnt_q + 1'b1;
  end
endmodule

// File: rtl/dti_status_core.sv
module dti_status_core
  import dti_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] expire,
  output logic [7:0] cmd,
  output logic [7:0] dlat,
  output logic [7:0] aux,
  output logic [7:0] tctrl,
  output logic [7:0] tdata,
  output logic [7:0] ts,
  output logic [7:0] isr,
  output logic [7:0] pre1,
  output logic [7:0] pre2
);
  logic [7:0] ts_n, isr_n;
  logic       ack_mode;
  logic       wr_data_port, wr_tctrl;

  assign ack_mode     = (cmd == ACK_CMD) && !tctrl[TC_VIEW];
  assign wr_data_port = wr_en && (wr_addr == A_DATA);
  assign wr_tctrl     = wr_en && (wr_addr == A_TCTRL);

  always_comb begin
    ts_n  = ts;
    isr_n = isr;
    // expiry first
    if (expire[0]) begin
      if (!tdata[6]) ts_n[7:6] = 2'b11;
      if (tctrl[TC_T1EN]) begin
        ts_n[2]  = 1'b1;
        isr_n[2] = 1'b1;
      end
    end
    if (expire[1]) begin
      if (!tdata[5]) begin
        ts_n[7] = 1'b1;
        ts_n[5] = 1'b1;
      end
      if (tctrl[TC_T2EN]) begin
        ts_n[1]  = 1'b1;
        isr_n[3] = 1'b1;
      end
    end
    // host write afterwards
    if (wr_data_port) begin
      if (ack_mode) begin
        if (wr_data[7]) ts_n[7:5] = 3'b000;
      end else if (tctrl[TC_DIRQ]) begin
        ts_n[0] = 1'b1;
        isr_n   = LOAD_ISR;
      end
    end
    if (wr_tctrl) begin
      if (!wr_data[TC_SBEN]) ts_n[4:3] = 2'b00;
      if (!wr_data[TC_DIRQ]) ts_n[0] = 1'b0;
      if (!ts_n[0] && (ts_n[4:3] == 2'b00)) isr_n[4] = 1'b0;
      if (!wr_data[TC_T1EN]) begin
        ts_n[2]  = 1'b0;
        isr_n[2] = 1'b0;
      end
      if (!wr_data[TC_T2EN]) begin
        ts_n[1]  = 1'b0;
        isr_n[3] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd   <= '0;
      dlat  <= '0;
      aux   <= '0;
      tctrl <= '0;
      tdata <= '0;
      ts    <= '0;
      isr   <= '0;
      pre1  <= '0;
      pre2  <= '0;
    end else begin
      ts  <= ts_n;
      isr <= isr_n;
      if (wr_en) begin
        unique case (wr_addr)
          A_CMDSTAT: cmd   <= wr_data;
          A_DATA: begin
            if (ack_mode) begin
              if (!wr_data[7]) tdata <= wr_data;
            end else begin
              dlat <= wr_data;
            end
          end
          A_AUX:   aux   <= wr_data;
          A_TCTRL: tctrl <= wr_data;
          A_PRE1:  pre1  <= wr_data;
          A_PRE2:  pre2  <= wr_data;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_timer_irq.sv
module dual_timer_irq
  import dti_pkg::*;
#(
  parameter int DIV_CYCLES = 4000,
  parameter int SLOW_RATIO = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq
);
  logic [7:0] cmd, dlat, aux, tctrl, tdata, ts, isr, pre1, pre2;
  logic       tick_fast, tick_slow;
  logic [NUM_TMR-1:0] tick_v, run_v, expire;
  logic [CNT_W-1:0]   preset_v [NUM_TMR];

  dti_tick_gen #(.DIV_CYCLES(DIV_CYCLES), .SLOW_RATIO(SLOW_RATIO)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow)
  );

  assign tick_v      = {tick_slow, tick_fast};
  assign run_v       = tdata[1:0];
  assign preset_v[0] = pre1;
  assign preset_v[1] = pre2;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    dti_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run_v[g]), .tick(tick_v[g]),
      .preset(preset_v[g]), .expire(expire[g])
    );
  end

  dti_status_core u_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .expire(expire), .cmd(cmd), .dlat(dlat), .aux(aux),
    .tctrl(tctrl), .tdata(tdata), .ts(ts), .isr(isr), .pre1(pre1), .pre2(pre2)
  );

  always_comb begin
    unique case (rd_addr)
      A_CMDSTAT: rd_data = tctrl[TC_VIEW] ? ts : aux;
      A_DATA:    rd_data = dlat;
      A_AUX:     rd_data = cmd;
      A_TCTRL:   rd_data = tctrl;
      A_ISR:     rd_data = isr;
      A_PRE1:    rd_data = pre1;
      A_PRE2:    rd_data = pre2;
      default:   rd_data = tdata;
    endcase
  end

  assign irq = |isr;
endmodule

// File: rtl/dti_checker.sv
module dti_checker
  import dti_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       irq,
  input logic [7:0] cmd,
  input logic [7:0] tctrl,
  input logic [7:0] tdata,
  input logic [7:0] ts,
  input logic [7:0] isr,
  input logic [1:0] expire
);
  logic ack_wr, plain_wr, ctl_wr;
  assign ack_wr   = wr_en && wr_addr == A_DATA && cmd == ACK_CMD && !tctrl[0];
  assign plain_wr = wr_en && wr_addr == A_DATA && !(cmd == ACK_CMD && !tctrl[0]);
  assign ctl_wr   = wr_en && wr_addr == A_TCTRL;

  p_ack_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr && wr_data[7] |=> ts[7:5] == 3'b000);

  p_load_isr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    plain_wr && tctrl[1] |=> isr == 8'h10 && ts[0] && irq);

  p_t1_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !wr_data[2] |=> !ts[2] && !isr[2]);

  p_t1_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] && !tdata[6] && !(wr_en && wr_addr == A_DATA) |=> ts[7] && ts[6]);

  p_t2_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire[1] && tctrl[3] && !ctl_wr && !plain_wr |=> ts[1] && isr[3]);

  p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && wr_data[5] == 1'b0 && wr_data[3:1] == 3'b000 &&
    isr[7:5] == 3'b000 && isr[1:0] == 2'b00 |=> !irq);
endmodule

bind dual_timer_irq dti_checker u_dti_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq(irq), .cmd(cmd), .tctrl(tctrl), .tdata(tdata),
  .ts(ts), .isr(isr), .expire(expire)
);

// File: tb/dual_timer_irq_bench.sv
module dual_timer_irq_bench;
  localparam int DIV = 5;
  localparam int RAT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       irq;

  always #10 clk = ~clk;

  dual_timer_irq #(.DIV_CYCLES(DIV), .SLOW_RATIO(RAT)) u_dual_timer_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // reference model
  logic [7:0] m_cmd, m_dat, m_aux, m_tc, m_isr, m_p1, m_p2, m_td, m_ts, m_c1, m_c2;
  int m_div, m_q;
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_exp(int a);
    case (a)
      0: return m_tc[0] ? m_ts : m_aux;
      1: return m_dat;
      2: return m_cmd;
      3: return m_tc;
      4: return m_isr;
      5: return m_p1;
      6: return m_p2;
      default: return m_td;
    endcase
  endfunction

  task automatic model_reset();
    {m_cmd, m_dat, m_aux, m_tc, m_isr, m_p1, m_p2, m_td, m_ts, m_c1, m_c2} = '0;
    m_div = 0;
    m_q = 0;
  endtask

  task automatic cyc(bit w, logic [2:0] a, logic [7:0] d);
    bit t1, t2, e1, e2, ack;
    logic [7:0] ts, isr, c1, c2;
    wr_en = w; wr_addr = a; wr_data = d;
    t1 = (m_div == DIV - 1);
    t2 = t1 && (m_q == RAT - 1);
    e1 = m_td[0] && t1 && m_c1 == 8'hFF;
    e2 = m_td[1] && t2 && m_c2 == 8'hFF;
    c1 = !m_td[0] ? m_p1 : t1 ? (m_c1 == 8'hFF ? m_p1 : m_c1 + 8'd1) : m_c1;
    c2 = !m_td[1] ? m_p2 : t2 ? (m_c2 == 8'hFF ? m_p2 : m_c2 + 8'd1) : m_c2;
    ts = m_ts; isr = m_isr;
    if (e1) begin
      if (!m_td[6]) ts[7:6] = 2'b11;
      if (m_tc[2]) begin ts[2] = 1; isr[2] = 1; end
    end
    if (e2) begin
      if (!m_td[5]) begin ts[7] = 1; ts[5] = 1; end
      if (m_tc[3]) begin ts[1] = 1; isr[3] = 1; end
    end
    ack = (m_cmd == 8'h04) && !m_tc[0];
    @(posedge clk);
    if (w) begin
      case (a)
        3'd0: m_cmd = d;
        3'd1: begin
          if (ack) begin
            if (d[7]) ts[7:5] = 3'b000; else m_td = d;
          end else begin
            m_dat = d;
            if (m_tc[1]) begin ts[0] = 1; isr = 8'h10; end
          end
        end
        3'd2: m_aux = d;
        3'd3: begin
          if (!d[5]) ts[4:3] = 2'b00;
          if (!d[1]) ts[0] = 0;
          if (!ts[0] && ts[4:3] == 2'b00) isr[4] = 0;
          if (!d[2]) begin ts[2] = 0; isr[2] = 0; end
          if (!d[3]) begin ts[1] = 0; isr[3] = 0; end
          m_tc = d;
        end
        3'd5: m_p1 = d;
        3'd6: m_p2 = d;
        default: ;
      endcase
    end
    m_ts = ts; m_isr = isr; m_c1 = c1; m_c2 = c2;
    if (t1) m_q = (m_q == RAT - 1) ? 0 : m_q + 1;
    m_div = t1 ? 0 : m_div + 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #1;
      chk(tag, rd_data, rd_exp(a));
    end
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, (m_isr != 0)});
  endtask

  task automatic rd_is(string tag, logic [2:0] a, logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      cyc(0, 3'd0, 8'd0);
      check_all(tag);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
    check_all("R10 reset");
    chk("R10 irq low", {7'd0, irq}, 8'd0);

    // R1: status view select
    cyc(1, 3'd2, 8'h5A);
    rd_is("R1 latch view", 3'd0, 8'h5A);
    cyc(1, 3'd3, 8'h01);
    rd_is("R1 timer view", 3'd0, 8'h00);
    cyc(1, 3'd3, 8'h00);

    // R3: plain data write with interrupt enabled
    cyc(1, 3'd0, 8'h00);
    cyc(1, 3'd3, 8'h02);
    cyc(1, 3'd1, 8'h33);
    rd_is("R3 data latch", 3'd1, 8'h33);
    rd_is("R3 isr load", 3'd4, 8'h10);
    chk("R3 irq", {7'd0, irq}, 8'd1);
    // R4: disabling clears bit 0 and interrupt bit 4
    cyc(1, 3'd3, 8'h00);
    rd_is("R4 isr cleared", 3'd4, 8'h00);
    chk("R8 irq drop", {7'd0, irq}, 8'd0);
    cyc(1, 3'd3, 8'h01);
    rd_is("R4 status bit0", 3'd0, 8'h00);

    // R10: writes to addresses 4 and 7 ignored
    cyc(1, 3'd4, 8'hFF);
    cyc(1, 3'd7, 8'hFF);
    rd_is("R10 isr ignored", 3'd4, 8'h00);
    rd_is("R10 tdata ignored", 3'd7, 8'h00);

    // R2/R6: timer 1 expiry, then acknowledge
    cyc(1, 3'd3, 8'h05);
    cyc(1, 3'd0, 8'h04);
    cyc(1, 3'd5, 8'hFE);
    cyc(1, 3'd3, 8'h04);
    cyc(1, 3'd1, 8'h01);
    rd_is("R2 tdata latched", 3'd7, 8'h01);
    run(3 * DIV, "R6 run");
    rd_is("R6 isr t1", 3'd4, 8'h04);
    chk("R6 irq", {7'd0, irq}, 8'd1);
    cyc(1, 3'd1, 8'h00);           // stop timer
    cyc(1, 3'd1, 8'h80);           // acknowledge
    cyc(1, 3'd3, 8'h05);
    rd_is("R2 ack clear", 3'd0, 8'h04);
    cyc(1, 3'd3, 8'h01);
    rd_is("R5 t1 clear", 3'd0, 8'h00);
    rd_is("R5 isr clear", 3'd4, 8'h00);

    // R6 mask: timer-data bit 6 suppresses the maskable pair
    cyc(1, 3'd3, 8'h00);
    cyc(1, 3'd5, 8'hFF);
    cyc(1, 3'd1, 8'h41);
    run(3 * DIV, "R6 mask");
    cyc(1, 3'd1, 8'h00);

    // R7: timer 2 on the slow tick
    cyc(1, 3'd6, 8'hFE);
    cyc(1, 3'd3, 8'h08);
    cyc(1, 3'd1, 8'h02);
    run(3 * DIV * RAT, "R7 run");
    rd_is("R7 isr t2", 3'd4, 8'h08);
    cyc(1, 3'd3, 8'h00);
    rd_is("R5 t2 clear", 3'd4, 8'h00);
    cyc(1, 3'd1, 8'h80);
    cyc(1, 3'd1, 8'h00);

    // R9: stopped timers with preset 0xFF stay silent
    cyc(1, 3'd5, 8'hFF);
    cyc(1, 3'd6, 8'hFF);
    cyc(1, 3'd3, 8'h0C);
    run(3 * DIV * RAT, "R9 stopped");
    rd_is("R9 isr quiet", 3'd4, 8'h00);

    // constrained random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom % 8);
      d = 8'($urandom);
      if (a == 3'd5 || a == 3'd6) d = d | 8'hF0;
      if (a == 3'd0 && ($urandom % 2 == 0)) d = 8'h04;
      if (a == 3'd1 && ($urandom % 3 == 0)) d = 8'h80;
      cyc(($urandom % 3) == 0, a, d);
      check_all("R9 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule